// File: doc/BRIEF.md
# Byte-Lane Read-Modify-Write Memory Controller

This block puts byte-granular writes on top of a synchronous single-port SRAM that can only be read or written as whole words. A requester presents a word address, a full data word, one enable per byte lane, and a read/write flag, and it uses a valid/ready handshake. The controller handles each request in one of three ways. A read returns the whole word. A write that enables every lane goes straight to the SRAM in one cycle. A write that enables only some lanes becomes an internal sequence: it reads the stored word, replaces the enabled bytes and writes the merged word back.

The SRAM has one cycle of read latency. The controller keeps exactly one request in flight. It holds ready low until that request has produced its single response pulse, so no later request can observe a word that is only half updated. A requester that works with byte addresses drops the lowest address bit to form the word address and uses that bit to select the lane. A build-time parameter fixes which half of the word each lane controls.

Top module: `bytelane_rmw_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it, req_ready is 1 and rsp_valid is 0.
- R2: A read accepted in cycle T gives rsp_valid=1 in cycle T+1, and rsp_rdata then holds the full 16-bit stored word whatever req_lanes holds.
- R3: A write with req_lanes=2'b11 writes req_wdata to the SRAM in its acceptance cycle T with no read phase, and rsp_valid is 1 in cycle T+1.
- R4: A write with exactly one lane enabled reads the SRAM in acceptance cycle T and writes the merged word back in T+1. rsp_valid is 0 in T+1 and 1 in T+2.
- R5: A single-lane write never changes the byte half that its lane does not select.
- R6: With BIG_ENDIAN=0, lane 0 controls bits [7:0] and lane 1 controls bits [15:8]. With BIG_ENDIAN=1, lane 0 controls bits [15:8] and lane 1 controls bits [7:0]. A byte written into a half is taken from the same bit positions of req_wdata.
- R7: A write with req_lanes=2'b00 issues no SRAM access, leaves memory unchanged, and gives rsp_valid=1 in cycle T+1.
- R8: Two single-lane writes to the same word address, one to each lane, leave the word holding both written bytes.
- R9: req_ready is 0 in every cycle in which a request is in flight, including the response cycle, and is 1 otherwise. A request is accepted only in a cycle in which req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_lanes | input | DW/8 | Byte lane enables for writes |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read word (zero for writes) |

## Verification
The properties assume that the requester never offers a request while the controller is busy. They also assume that every request is held for exactly one accepting cycle and that reads only touch words that were written earlier. The stimulus meets these conditions as follows. It fills every word with a full write first. It raises req_valid only at a negedge after it has seen ready high, and it drops req_valid at the next negedge. It then runs a seeded random mix of reads, full writes, single-lane writes and empty-lane writes against a word-level shadow for each endianness.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MERGE,
        ST_DONE
    } rmw_state_e;

    typedef enum logic [1:0] {
        OP_READ,
        OP_WFULL,
        OP_WPART,
        OP_WNONE
    } rmw_op_e;

    // Physical half that a logical lane drives
    function automatic int lane_half(input int lane, input int nlanes, input bit big);
        return big ? (nlanes - 1 - lane) : lane;
    endfunction
endpackage

// File: rtl/rmw_word_sram.sv
module rmw_word_sram #(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    rdata     <= mem[addr];
        end
    end
endmodule

// File: rtl/rmw_lane_merge.sv
module rmw_lane_merge
    import rmw_pkg::*;
#(
    parameter int DW         = 16,
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic [DW-1:0]        old_word,
    input  logic [DW-1:0]        new_word,
    input  logic [DW/BYTE_W-1:0] lanes,
    output logic [DW-1:0]        merged
);
    localparam int NL = DW / BYTE_W;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        localparam int H = lane_half(i, NL, BIG_ENDIAN);
        assign merged[H*BYTE_W +: BYTE_W] = lanes[i] ? new_word[H*BYTE_W +: BYTE_W]
                                                     : old_word[H*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/rmw_ctrl_fsm.sv
module rmw_ctrl_fsm
    import rmw_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [AW-1:0]        req_addr,
    input  logic [DW/BYTE_W-1:0] req_lanes,
    input  logic [DW-1:0]        req_wdata,
    output logic                 rsp_valid,
    output logic [DW-1:0]        rsp_rdata,
    output logic                 sram_en,
    output logic                 sram_we,
    output logic [AW-1:0]        sram_addr,
    output logic [DW-1:0]        sram_wdata,
    input  logic [DW-1:0]        sram_rdata,
    output logic [DW-1:0]        held_wdata,
    output logic [DW/BYTE_W-1:0] held_lanes,
    input  logic [DW-1:0]        merged_word
);
    localparam int NL = DW / BYTE_W;

    typedef struct packed {
        rmw_op_e        op;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  wdata;
        logic [NL-1:0]  lanes;
    } held_req_t;

    rmw_state_e state_q, state_d;
    held_req_t  hold_q;
    rmw_op_e    op_in;
    logic       accept;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    always_comb begin
        if (!req_write)                  op_in = OP_READ;
        else if (req_lanes == '1)        op_in = OP_WFULL;
        else if (req_lanes == '0)        op_in = OP_WNONE;
        else                             op_in = OP_WPART;
    end

    always_comb begin
        state_d    = state_q;
        sram_en    = 1'b0;
        sram_we    = 1'b0;
        sram_addr  = req_addr;
        sram_wdata = req_wdata;
        unique case (state_q)
            ST_IDLE: if (accept) begin
                sram_en = (op_in != OP_WNONE);
                sram_we = (op_in == OP_WFULL);
                state_d = (op_in == OP_WPART) ? ST_MERGE : ST_DONE;
            end
            ST_MERGE: begin
                sram_en    = 1'b1;
                sram_we    = 1'b1;
                sram_addr  = hold_q.addr;
                sram_wdata = merged_word;
                state_d    = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            hold_q  <= '{op: OP_READ, addr: '0, wdata: '0, lanes: '0};
        end else begin
            state_q <= state_d;
            if (accept) hold_q <= '{op: op_in, addr: req_addr, wdata: req_wdata, lanes: req_lanes};
        end
    end

    assign held_wdata = hold_q.wdata;
    assign held_lanes = hold_q.lanes;
    assign rsp_valid  = (state_q == ST_DONE);
    assign rsp_rdata  = (rsp_valid && hold_q.op == OP_READ) ? sram_rdata : '0;
endmodule

// File: rtl/bytelane_rmw_ctrl.sv
module bytelane_rmw_ctrl
    import rmw_pkg::*;
#(
    parameter int AW         = 10,
    parameter int DW         = 16,
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [AW-1:0]        req_addr,
    input  logic [DW/BYTE_W-1:0] req_lanes,
    input  logic [DW-1:0]        req_wdata,
    output logic                 rsp_valid,
    output logic [DW-1:0]        rsp_rdata
);
    localparam int NL = DW / BYTE_W;

    logic          sram_en, sram_we;
    logic [AW-1:0] sram_addr;
    logic [DW-1:0] sram_wdata, sram_rdata, held_wdata, merged_word;
    logic [NL-1:0] held_lanes;

    rmw_ctrl_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_lanes  (req_lanes),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .sram_en    (sram_en),
        .sram_we    (sram_we),
        .sram_addr  (sram_addr),
        .sram_wdata (sram_wdata),
        .sram_rdata (sram_rdata),
        .held_wdata (held_wdata),
        .held_lanes (held_lanes),
        .merged_word(merged_word)
    );

    rmw_lane_merge #(.DW(DW), .BIG_ENDIAN(BIG_ENDIAN)) u_merge (
        .old_word(sram_rdata),
        .new_word(held_wdata),
        .lanes   (held_lanes),
        .merged  (merged_word)
    );

    rmw_word_sram #(.AW(AW), .DW(DW)) u_sram (
        .clk  (clk),
        .en   (sram_en),
        .we   (sram_we),
        .addr (sram_addr),
        .wdata(sram_wdata),
        .rdata(sram_rdata)
    );
endmodule

// File: rtl/rmw_chk.sv
module rmw_chk
    import rmw_pkg::*;
#(
    parameter int AW         = 10,
    parameter int DW         = 16,
    parameter bit BIG_ENDIAN = 1'b0
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 req_write,
    input logic [AW-1:0]        req_addr,
    input logic [DW/BYTE_W-1:0] req_lanes,
    input logic [DW-1:0]        req_wdata,
    input logic                 rsp_valid,
    input logic                 sram_en,
    input logic                 sram_we,
    input logic [AW-1:0]        sram_addr,
    input logic [DW-1:0]        sram_wdata,
    input logic [DW-1:0]        sram_rdata
);
    localparam int NL = DW / BYTE_W;

    logic          acc, acc_rd, acc_full, acc_part, acc_none;
    logic [DW-1:0] bit_mask;

    assign acc      = req_valid && req_ready;
    assign acc_rd   = acc && !req_write;
    assign acc_full = acc && req_write && (req_lanes == '1);
    assign acc_none = acc && req_write && (req_lanes == '0);
    assign acc_part = acc && req_write && !acc_full && !acc_none;

    always_comb begin
        bit_mask = '0;
        for (int i = 0; i < NL; i++)
            if (req_lanes[i]) bit_mask[lane_half(i, NL, BIG_ENDIAN)*BYTE_W +: BYTE_W] = '1;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> (req_ready && !rsp_valid));
    // R2
    read_issue_chk: assert property (@(posedge clk) disable iff (rst)
        acc_rd |-> (sram_en && !sram_we && sram_addr == req_addr));
    // R2
    read_rsp_chk: assert property (@(posedge clk) disable iff (rst) acc_rd |=> rsp_valid);
    // R3
    full_write_chk: assert property (@(posedge clk) disable iff (rst)
        acc_full |-> (sram_en && sram_we && sram_addr == req_addr && sram_wdata == req_wdata));
    // R4
    part_read_chk: assert property (@(posedge clk) disable iff (rst)
        acc_part |-> (sram_en && !sram_we));
    // R4
    part_wb_chk: assert property (@(posedge clk) disable iff (rst)
        acc_part |=> (sram_en && sram_we && !rsp_valid && sram_addr == $past(req_addr)));
    // R5
    keep_half_chk: assert property (@(posedge clk) disable iff (rst)
        acc_part |=> (((sram_wdata ^ sram_rdata) & ~$past(bit_mask)) == '0));
    // R6
    new_half_chk: assert property (@(posedge clk) disable iff (rst)
        acc_part |=> (((sram_wdata ^ $past(req_wdata)) & $past(bit_mask)) == '0));
    // R7
    none_write_chk: assert property (@(posedge clk) disable iff (rst)
        acc_none |=> (!sram_en && rsp_valid));
    // R9
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst) rsp_valid |-> !req_ready);
endmodule

bind bytelane_rmw_ctrl rmw_chk #(.AW(AW), .DW(DW), .BIG_ENDIAN(BIG_ENDIAN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_lanes (req_lanes),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .sram_en   (sram_en),
    .sram_we   (sram_we),
    .sram_addr (sram_addr),
    .sram_wdata(sram_wdata),
    .sram_rdata(sram_rdata)
);

// File: tb/bytelane_rmw_ctrl_tb.sv
module bytelane_rmw_ctrl_tb;
    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr  = '0;
    logic [1:0]    req_lanes = '0;
    logic [15:0]   req_wdata = '0;
    logic          rdy_le, rdy_be, vld_le, vld_be;
    logic [15:0]   rd_le, rd_be;

    logic [15:0]   sh_le [DEPTH];
    logic [15:0]   sh_be [DEPTH];
    int            n_chk = 0;
    int            n_fail = 0;
    bit            finished = 1'b0;

    always #4 clk = ~clk;

    bytelane_rmw_ctrl #(.AW(AW), .DW(16), .BIG_ENDIAN(1'b0)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy_le),
        .req_write(req_write), .req_addr(req_addr), .req_lanes(req_lanes),
        .req_wdata(req_wdata), .rsp_valid(vld_le), .rsp_rdata(rd_le));

    bytelane_rmw_ctrl #(.AW(AW), .DW(16), .BIG_ENDIAN(1'b1)) u_dut_be (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy_be),
        .req_write(req_write), .req_addr(req_addr), .req_lanes(req_lanes),
        .req_wdata(req_wdata), .rsp_valid(vld_be), .rsp_rdata(rd_be));

    function automatic logic [15:0] exp_merge(input logic [15:0] old, input logic [15:0] d,
                                              input logic [1:0] ln, input bit big);
        logic [15:0] r;
        r = old;
        for (int k = 0; k < 2; k++) begin
            int h;
            h = big ? 1 - k : k;
            if (ln[k]) r[h*8 +: 8] = d[h*8 +: 8];
        end
        return r;
    endfunction

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic do_req(input logic wr, input logic [AW-1:0] a, input logic [15:0] d,
                          input logic [1:0] ln);
        logic  part;
        string tag;
        part = wr && (ln == 2'b01 || ln == 2'b10);
        tag  = !wr ? "R2" : part ? "R4" : (ln == 2'b00) ? "R7" : "R3";
        @(negedge clk);
        check("R9 ready idle", {rdy_le, rdy_be}, 2'b11);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_lanes = ln;
        @(negedge clk);
        req_valid = 1'b0;
        if (part) begin
            check("R4 no rsp during merge", {vld_le, vld_be}, 2'b00);
            check("R9 busy merge", {rdy_le, rdy_be}, 2'b00);
            @(negedge clk);
        end
        check(tag, {vld_le, vld_be}, 2'b11);
        check("R9 busy rsp", {rdy_le, rdy_be}, 2'b00);
        if (!wr) begin
            check("R2 R5 R6 read le", rd_le, sh_le[a]);
            check("R2 R5 R6 read be", rd_be, sh_be[a]);
        end else begin
            sh_le[a] = exp_merge(sh_le[a], d, ln, 1'b0);
            sh_be[a] = exp_merge(sh_be[a], d, ln, 1'b1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0005eed1));
        // R1 reset state
        @(negedge clk);
        check("R1 ready in reset", {rdy_le, rdy_be}, 2'b11);
        check("R1 no rsp in reset", {vld_le, vld_be}, 2'b00);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1 idle after reset", {rdy_le, rdy_be, vld_le, vld_be}, 4'b1100);

        for (int w = 0; w < DEPTH; w++) do_req(1'b1, AW'(w), 16'(w * 16'h9e37 + 16'h1234), 2'b11);

        // R6 directed: lane 0 lands in low half (le) or high half (be)
        do_req(1'b1, 10'd5, 16'h0000, 2'b11);
        do_req(1'b1, 10'd5, 16'hABCD, 2'b01);
        do_req(1'b0, 10'd5, 16'h0000, 2'b00);
        check("R6 le lane0 low half", rd_le, 16'h00CD);
        check("R6 be lane0 high half", rd_be, 16'hAB00);
        // R8 both lanes by separate writes
        do_req(1'b1, 10'd7, 16'h5555, 2'b11);
        do_req(1'b1, 10'd7, 16'h11EE, 2'b01);
        do_req(1'b1, 10'd7, 16'h77AA, 2'b10);
        do_req(1'b0, 10'd7, 16'h0000, 2'b01);
        check("R8 le combined", rd_le, 16'h77EE);
        check("R8 be combined", rd_be, 16'h11AA);
        // R7 empty lanes leave memory alone
        do_req(1'b1, 10'd9, 16'hFFFF, 2'b00);
        do_req(1'b0, 10'd9, 16'h0000, 2'b10);
        // R5 boundary addresses
        do_req(1'b1, 10'd0, 16'hC3C3, 2'b10);
        do_req(1'b0, 10'd0, 16'h0000, 2'b11);
        do_req(1'b1, AW'(DEPTH - 1), 16'h3C3C, 2'b01);
        do_req(1'b0, AW'(DEPTH - 1), 16'h0000, 2'b00);

        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] a;
            logic [15:0]   d;
            int            kind;
            a    = AW'($urandom % 32);
            d    = 16'($urandom);
            kind = int'($urandom % 6);
            case (kind)
                0, 1:    do_req(1'b0, a, d, 2'($urandom));
                2:       do_req(1'b1, a, d, 2'b11);
                3, 4:    begin
                             do_req(1'b1, a, d, ($urandom % 2) ? 2'b01 : 2'b10);
                             do_req(1'b0, a, 16'h0, 2'b00);
                         end
                default: do_req(1'b1, a, d, 2'b00);
            endcase
        end

        for (int w = 0; w < DEPTH; w++) do_req(1'b0, AW'(w), 16'h0, 2'b11);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule